// File: doc/BRIEF.md
# Pause-Width Coded Frame Transmitter

This block serialises a frame of up to sixteen bits onto one carrier-control line. Each bit fills a slot whose total length carries its value. The slot opens with the carrier switched off for a fixed pause, and the carrier then returns for the rest of the slot. A short slot means 0 and a long slot means 1. An upstream prescaler supplies a one-clock tick enable, and all durations are counted in those ticks (nominally the system clock divided by 32).

A start strobe accepted while idle captures the data word and the bit count. The bits go out least significant first. After the final bit, one extra carrier-off pause closes the frame. When that pause ends, the block raises a one-clock completion pulse together with a restart pulse for a shared timing reference, so a receiver can measure the reply delay from the end of the frame.

Top module: `pwf_frame_tx`

## Requirements
- R1: After reset and whenever idle, `carrier_o` is 1, `busy_o` is 0, and `done_o` and `ref_restart_o` are 0.
- R2: Every bit slot begins with exactly 30 ticks of `carrier_o` = 0, after which `carrier_o` returns to 1.
- R3: A 1-bit slot lasts 150 ticks in total, pause included.
- R4: A 0-bit slot lasts 90 ticks in total, pause included.
- R5: Bit 0 of `data_i` is sent first, then bit 1, and so on upward.
- R6: After the last bit slot, `carrier_o` is 0 for 30 more ticks, and the block then returns to idle with the carrier on.
- R7: `done_o` and `ref_restart_o` are 1 for exactly one clock, the clock after the edge that ends the closing pause. `busy_o` falls on that same edge.
- R8: A `start_i` that arrives while `busy_o` is 1 has no effect on the frame in progress.
- R9: A bit count of 0 sends only the closing pause. Counts of 17 to 31 are treated as 16.
- R10: Time advances only on clocks where `tick_en` is 1. With no tick, every output holds its value.
- R11: `data_i` and `nbits_i` are sampled only on the accepted start. Later changes do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock time-base tick from the prescaler |
| start_i | input | 1 | Begin a frame (acted on only when idle) |
| data_i | input | 16 | Frame bits, LSB sent first |
| nbits_i | input | 5 | Number of bits to send, clamped to 16 |
| carrier_o | output | 1 | Carrier control: 1 = on, 0 = pause |
| busy_o | output | 1 | High from the accepted start until the closing pause ends |
| done_o | output | 1 | One-clock pulse at frame end |
| ref_restart_o | output | 1 | One-clock pulse that restarts the shared reply-gap timer |

## Verification
A mixed word at full length with a tick on every clock separates the short and long slots and shows the bit order. A zero count and an over-range count of all ones probe both clamp boundaries. The over-range frame runs with a tick on only one clock in three, which exposes any timing that depends on clocks rather than ticks. An all-zero frame is hit with random start pulses and a changing data word and count while busy, so any re-trigger or late sampling shows up in the carrier trace. A single-bit frame under an irregular tick pattern checks the shortest frame that still carries data.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BIT   = 2'd1,
    PH_CLOSE = 2'd2
  } phase_t;

  // Slot length in ticks for one coded bit.
  function automatic int slot_ticks(input logic b, input int one_t, input int zero_t);
    return b ? one_t : zero_t;
  endfunction

  // Requested bit count limited to the frame capacity.
  function automatic int clamp_bits(input int req, input int max_b);
    return (req > max_b) ? max_b : req;
  endfunction

endpackage

// File: rtl/pwf_slot_timer.sv
module pwf_slot_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic          tick_en,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          slot_last
);

  assign slot_last = run && tick_en && (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clear || slot_last)
      cnt <= '0;
    else if (run && tick_en)
      cnt <= cnt + CW'(1);
  end

  // The count stays inside the current slot.
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));

endmodule

// File: rtl/pwf_bit_seq.sv
module pwf_bit_seq #(
  parameter int MAX_BITS = 16,
  parameter int NW       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] data_in,
  input  logic [NW-1:0]       count_in,
  input  logic                advance,
  output logic                cur_bit,
  output logic                last_bit
);

  logic [MAX_BITS-1:0] shreg;
  logic [NW-1:0]       remaining;

  assign cur_bit  = shreg[0];
  assign last_bit = (remaining == NW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      remaining <= '0;
    end else if (load) begin
      shreg     <= data_in;
      remaining <= count_in;
    end else if (advance) begin
      shreg     <= {1'b0, shreg[MAX_BITS-1:1]};
      remaining <= remaining - NW'(1);
    end
  end

  // The bit counter never holds more than the frame capacity.
  assert_remaining_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    remaining <= NW'(MAX_BITS));

endmodule

// File: rtl/pwf_frame_tx.sv
module pwf_frame_tx
  import pwf_pkg::*;
#(
  parameter int MAX_BITS    = 16,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  localparam int NW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [NW-1:0]       nbits_i,
  output logic                carrier_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                ref_restart_o
);

  localparam int LONGEST = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;
  localparam int CW      = $clog2(LONGEST + 1);

  phase_t        phase;
  logic          accept;
  logic [NW-1:0] count_eff;
  logic          cur_bit;
  logic          last_bit;
  logic [CW-1:0] limit;
  logic [CW-1:0] slot_cnt;
  logic          slot_last;
  logic          bit_end;
  logic          close_end;
  logic          done_q;

  assign accept    = start_i && (phase == PH_IDLE);
  assign count_eff = NW'(clamp_bits(int'(nbits_i), MAX_BITS));
  assign limit     = (phase == PH_CLOSE) ? CW'(PAUSE_TICKS)
                                         : CW'(slot_ticks(cur_bit, ONE_TICKS, ZERO_TICKS));
  assign bit_end   = slot_last && (phase == PH_BIT);
  assign close_end = slot_last && (phase == PH_CLOSE);

  pwf_slot_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .run       (phase != PH_IDLE),
    .tick_en   (tick_en),
    .limit     (limit),
    .cnt       (slot_cnt),
    .slot_last (slot_last)
  );

  pwf_bit_seq #(.MAX_BITS(MAX_BITS), .NW(NW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .data_in  (data_i),
    .count_in (count_eff),
    .advance  (bit_end),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= close_end;
      case (phase)
        PH_IDLE:  if (accept) phase <= (count_eff == '0) ? PH_CLOSE : PH_BIT;
        PH_BIT:   if (bit_end && last_bit) phase <= PH_CLOSE;
        PH_CLOSE: if (close_end) phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assign carrier_o     = (phase == PH_IDLE) ||
                         ((phase == PH_BIT) && (slot_cnt >= CW'(PAUSE_TICKS)));
  assign busy_o        = (phase != PH_IDLE);
  assign done_o        = done_q;
  assign ref_restart_o = done_q;

  assert_idle_carrier_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> carrier_o);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_en) |=> ($stable(carrier_o) && busy_o));

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !tick_en) |=> ($stable(carrier_o) && $stable(slot_cnt)));

endmodule

// File: tb/tb_pwf_frame_tx.sv
`timescale 1ns/1ps
module tb_pwf_frame_tx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        start_i;
  logic [15:0] data_i;
  logic [4:0]  nbits_i;
  logic        carrier_o, busy_o, done_o, ref_restart_o;

  always #2 clk = ~clk;

  pwf_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start_i(start_i),
    .data_i(data_i), .nbits_i(nbits_i), .carrier_o(carrier_o),
    .busy_o(busy_o), .done_o(done_o), .ref_restart_o(ref_restart_o)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  int    tick_period = 1;
  int    tick_phase = 0;
  bit    tick_random = 0;

  // Behavioural model: queue of expected carrier levels, one per tick.
  int q[$];
  bit m_busy = 0;
  bit m_done = 0;

  function automatic void build_frame(logic [15:0] d, int n);
    q.delete();
    if (n > 16) n = 16;
    for (int i = 0; i < n; i++) begin
      int len = d[i] ? 150 : 90;
      for (int k = 0; k < 30; k++) q.push_back(0);
      for (int k = 30; k < len; k++) q.push_back(1);
    end
    for (int k = 0; k < 30; k++) q.push_back(0);
  endfunction

  task automatic compare();
    bit ec = m_busy ? q[0][0] : 1'b1;
    vectors++;
    if (carrier_o !== ec || busy_o !== m_busy || done_o !== m_done || ref_restart_o !== m_done) begin
      miscompares++;
      $display("FAIL %s: carrier/busy/done/ref = %b%b%b%b expected %b%b%b%b at %0t",
               cur_req, carrier_o, busy_o, done_o, ref_restart_o, ec, m_busy, m_done, m_done, $time);
    end
  endtask

  task automatic step(bit st, logic [15:0] d, logic [4:0] n);
    bit tk;
    @(negedge clk);
    compare();
    if (tick_random) tk = ($urandom % 3) == 0;
    else             tk = (tick_phase == 0);
    tick_phase = (tick_phase + 1) % tick_period;
    tick_en = tk; start_i = st; data_i = d; nbits_i = n;
    m_done = 0;
    if (m_busy) begin
      if (tk) begin
        void'(q.pop_front());
        if (q.size() == 0) begin m_busy = 0; m_done = 1; end
      end
    end else if (st) begin
      build_frame(d, int'(n));
      m_busy = 1;
    end
  endtask

  task automatic run_frame(logic [15:0] d, logic [4:0] n, bit disturb, int idle_after);
    step(1'b1, d, n);
    while (m_busy) begin
      if (disturb) step(1'($urandom % 7 == 0), 16'($urandom), 5'($urandom));
      else         step(1'b0, d, n);
    end
    for (int i = 0; i < idle_after; i++) step(1'b0, d, n);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; start_i = 1'b0; data_i = '0; nbits_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";                       // reset / idle state
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 5'd0);

    cur_req = "R2 R3 R4 R5 R6 R7";        // mixed word, full length, tick every clock
    run_frame(16'hA5C3, 5'd16, 1'b0, 4);

    cur_req = "R9 zero count";
    run_frame(16'hFFFF, 5'd0, 1'b0, 3);

    cur_req = "R9 clamp R10 sparse tick"; // count 31, tick one clock in three
    tick_period = 3; tick_phase = 0;
    run_frame(16'hFFFF, 5'd31, 1'b0, 6);

    cur_req = "R8 R11 restart and input changes while busy";
    tick_period = 1; tick_phase = 0;
    run_frame(16'h0000, 5'd5, 1'b1, 3);

    cur_req = "R3 R10 single bit irregular ticks";
    tick_random = 1;
    run_frame(16'h0001, 5'd1, 1'b0, 5);

    cur_req = "R4 R5 back-to-back start after done";
    tick_random = 0;
    run_frame(16'h0002, 5'd2, 1'b0, 0);
    run_frame(16'h0001, 5'd2, 1'b0, 3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL R7 watchdog: frame never completed, got busy=%b expected 0", busy_o);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule